// File: doc/BRIEF.md
# Paged Indirect Effective-Address Unit

This unit turns a memory-reference instruction of a 12-bit accumulator machine into the final operand address. It receives the instruction word together with the address the instruction was fetched from. It forms a 12-bit address from a page-select bit and a 7-bit offset. When the instruction asks for indirection, it reads the pointer word through a simple synchronous memory port and returns that word as the effective address. Eight fixed low-memory pointer locations step forward by one on every indirect use. The incremented pointer is written back before it serves as the address.

The caller presents a request for one cycle while the unit is idle and waits for `done`. A direct reference completes in the cycle it is presented and causes no memory traffic. An indirect reference takes one read cycle. It takes one further write cycle when the pointer sits in the auto-increment range. The operation applied to the operand, and the fetch of the instruction itself, belong to other blocks.

Instruction fields used: bits [6:0] offset, bit 7 page select, bit 8 indirect. Bits [11:9] carry the opcode, and this unit does not look at them.

Top module: `pageIndEaUnit`

## Requirements
- R1: With instruction bit 7 at 0, the formed address is the 7-bit offset (bits [6:0]) with the upper five bits zero.
- R2: With instruction bit 7 at 1, the upper five address bits equal bits [11:7] of `instrAddr`, and the lower seven come from the offset.
- R3: With instruction bit 8 at 0, `done` rises in the request cycle with `effAddr` equal to the formed address. `memRdEn`, `memWrEn` and `busy` all stay low.
- R4: With bit 8 at 1 and a formed address outside 8..15, `memRdEn` is high in the request cycle with `memAddr` equal to the formed address. In the next cycle `done` is high and `effAddr` equals the word read, with no further level of indirection and no write.
- R5: With bit 8 at 1 and a formed address in 8..15, the cycle after the read shows neither `done` nor a write. The cycle after that raises `memWrEn` and `done` together, with `memAddr` equal to the formed address and `memWrData` and `effAddr` both equal to the read word plus one.
- R6: The auto-increment wraps modulo 4096, so a pointer of 0xFFF yields 0x000.
- R7: A direct reference to an address in 8..15 neither reads nor writes memory and leaves the stored word unchanged.
- R8: `busy` is high from the cycle after an indirect request is accepted through its `done` cycle. A request presented while `busy` is high is ignored and produces no `done` of its own.
- R9: The auto-increment range is decided on the formed address, so a current-page reference from an instruction on page zero that lands in 8..15 also increments.
- R10: After reset the unit is idle, with `busy`, `done`, `memRdEn` and `memWrEn` low while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only while idle |
| instrWord | input | 12 | Memory-reference instruction |
| instrAddr | input | 12 | Address the instruction came from |
| busy | output | 1 | Indirect reference in flight |
| done | output | 1 | Effective address valid this cycle |
| effAddr | output | 12 | Effective address |
| memRdEn | output | 1 | Memory read strobe, data returns next cycle |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | 12 | Memory address |
| memWrData | output | 12 | Memory write data |
| memRdData | input | 12 | Memory read data, valid the cycle after `memRdEn` |

## Verification
On every cycle the assertions check several port-level relations. Read and write never occur together. A write goes to the address read two cycles earlier and carries the value read plus one. A direct completion is free of memory traffic. A completion without a write returns the word read, and the offset bits always pass straight through. The page selection, the exact range of eight auto-increment locations, the wrap at 0xFFF, the write-back seen in memory afterwards, and the refusal of requests presented while busy can only be shown by the bench scenarios. Those scenarios compare every cycle with a behavioural model that keeps its own memory.

// File: rtl/eaPkg.sv
package eaPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } eaState_t;

  typedef enum logic [1:0] {
    SEL_FORMED = 2'd0,
    SEL_RDATA  = 2'd1,
    SEL_PTR    = 2'd2
  } effSel_t;

  typedef struct packed {
    logic    captureReq;
    logic    capturePtr;
    logic    addrFromReg;
    effSel_t effSel;
  } eaCtl_t;

endpackage

// File: rtl/eaDatapath.sv
module eaDatapath
  import eaPkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int OFF_W     = 7,
  parameter int AUTO_BASE = 8,
  parameter int AUTO_NUM  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] instrWord,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic [ADDR_W-1:0] memRdData,
  input  eaCtl_t            ctl,
  output logic              isIndirect,
  output logic              autoHit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWrData,
  output logic [ADDR_W-1:0] effAddr
);

  localparam int PAGE_W   = ADDR_W - OFF_W;
  localparam int PAGE_BIT = OFF_W;
  localparam int IND_BIT  = OFF_W + 1;

  logic [PAGE_W-1:0]   pageField;
  logic [ADDR_W-1:0]   formedLive;
  logic [ADDR_W-1:0]   formedReg;
  logic [ADDR_W-1:0]   ptrReg;
  logic [ADDR_W-1:0]   ptrNext;
  logic                autoReg;
  logic [AUTO_NUM-1:0] autoMatch;

  // page select: zero page or the page of the instruction itself
  always_comb begin
    if (instrWord[PAGE_BIT]) pageField = instrAddr[ADDR_W-1 -: PAGE_W];
    else                     pageField = '0;
  end

  assign formedLive = {pageField, instrWord[OFF_W-1:0]};
  assign isIndirect = instrWord[IND_BIT];

  // one comparator per auto-increment location
  generate
    for (genvar gi = 0; gi < AUTO_NUM; gi++) begin : gAuto
      assign autoMatch[gi] = (formedLive == ADDR_W'(AUTO_BASE + gi));
    end
  endgenerate

  assign ptrNext = memRdData + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      formedReg <= '0;
      autoReg   <= 1'b0;
      ptrReg    <= '0;
    end else begin
      if (ctl.captureReq) begin
        formedReg <= formedLive;
        autoReg   <= |autoMatch;
      end
      if (ctl.capturePtr) ptrReg <= ptrNext;
    end
  end

  assign autoHit   = autoReg;
  assign memAddr   = ctl.addrFromReg ? formedReg : formedLive;
  assign memWrData = ptrReg;

  always_comb begin
    unique case (ctl.effSel)
      SEL_RDATA: effAddr = memRdData;
      SEL_PTR:   effAddr = ptrReg;
      default:   effAddr = formedLive;
    endcase
  end

  AST_PTR_INC: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capturePtr |=> (memWrData == $past(memRdData) + ADDR_W'(1))); // R6

endmodule

// File: rtl/eaControl.sv
module eaControl
  import eaPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   isIndirect,
  input  logic   autoHit,
  output eaCtl_t ctl,
  output logic   busy,
  output logic   done,
  output logic   memRdEn,
  output logic   memWrEn
);

  eaState_t state, stateNext;

  always_comb begin
    stateNext       = state;
    ctl.captureReq  = 1'b0;
    ctl.capturePtr  = 1'b0;
    ctl.addrFromReg = 1'b1;
    ctl.effSel      = SEL_FORMED;
    done            = 1'b0;
    memRdEn         = 1'b0;
    memWrEn         = 1'b0;
    unique case (state)
      ST_IDLE: begin
        ctl.addrFromReg = 1'b0;
        if (reqValid) begin
          if (isIndirect) begin
            memRdEn        = 1'b1;
            ctl.captureReq = 1'b1;
            stateNext      = ST_READ;
          end else begin
            done = 1'b1;
          end
        end
      end
      ST_READ: begin
        if (autoHit) begin
          ctl.capturePtr = 1'b1;
          stateNext      = ST_WRITE;
        end else begin
          ctl.effSel = SEL_RDATA;
          done       = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      ST_WRITE: begin
        ctl.effSel = SEL_PTR;
        memWrEn    = 1'b1;
        done       = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WRITE) |-> ($past(state) == ST_READ)); // R5

endmodule

// File: rtl/pageIndEaUnit.sv
module pageIndEaUnit
  import eaPkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int OFF_W     = 7,
  parameter int AUTO_BASE = 8,
  parameter int AUTO_NUM  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] instrWord,
  input  logic [ADDR_W-1:0] instrAddr,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] effAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWrData,
  input  logic [ADDR_W-1:0] memRdData
);

  eaCtl_t ctl;
  logic   isIndirect;
  logic   autoHit;

  eaControl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .isIndirect(isIndirect),
    .autoHit   (autoHit),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn)
  );

  eaDatapath #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .AUTO_BASE(AUTO_BASE),
    .AUTO_NUM (AUTO_NUM)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .instrWord (instrWord),
    .instrAddr (instrAddr),
    .memRdData (memRdData),
    .ctl       (ctl),
    .isIndirect(isIndirect),
    .autoHit   (autoHit),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .effAddr   (effAddr)
  );

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn)); // R5

  AST_DIRECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (done && !busy) |-> (!memRdEn && !memWrEn)); // R3

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (done && !busy) |-> (effAddr[OFF_W-1:0] == instrWord[OFF_W-1:0])); // R1

  AST_READ_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (done && busy && !memWrEn) |-> (effAddr == memRdData)); // R4

  AST_READ_THEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> busy); // R8

  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !reqValid) |-> !done); // R10

  AST_WRITE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memAddr == $past(memAddr, 2))); // R5

  AST_WRITE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (done && effAddr == memWrData)); // R5

endmodule

// File: tb/test_pageIndEaUnit.sv
`timescale 1ns/1ps
module test_pageIndEaUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [11:0] instrWord = '0;
  logic [11:0] instrAddr = '0;
  logic        busy, done, memRdEn, memWrEn;
  logic [11:0] effAddr, memAddr, memWrData;
  logic [11:0] memRdData = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pageIndEaUnit i_pageIndEaUnit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .instrWord(instrWord), .instrAddr(instrAddr),
    .busy(busy), .done(done), .effAddr(effAddr),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData)
  );

  // behavioural memory: sparse storage with a computed fill pattern
  logic [11:0] memArr [int];

  function automatic logic [11:0] memVal(int a);
    if (memArr.exists(a)) return memArr[a];
    return 12'((a * 5 + 7) & 12'hFFF);
  endfunction

  always @(posedge clk) begin
    if (memRdEn) memRdData <= memVal(int'(memAddr));
    if (memWrEn) memArr[int'(memAddr)] = memWrData;
  end

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(bit ind, bit pg, int off);
    return {3'b001, ind, pg, 7'(off)};
  endfunction

  // drive one request and compare every cycle against the model
  task automatic runReq(logic [11:0] instr, logic [11:0] pc, string pgTag, bit holdReq);
    logic [11:0] formed, expEa, ptr;
    bit ind, autoInc;
    formed  = instr[7] ? {pc[11:7], instr[6:0]} : {5'b0, instr[6:0]};
    ind     = instr[8];
    autoInc = ind && (formed >= 12'd8) && (formed <= 12'd15);
    ptr     = memVal(int'(formed));
    expEa   = !ind ? formed : (autoInc ? ptr + 12'd1 : ptr);

    @(negedge clk);
    reqValid = 1'b1; instrWord = instr; instrAddr = pc;
    #1;
    if (!ind) begin
      chk({pgTag, " effAddr"}, effAddr, formed);
      chk("R3 done", 12'(done), 12'd1);
      chk("R3 traffic", 12'({memRdEn, memWrEn, busy}), 12'd0);
      @(negedge clk);
      reqValid = 1'b0;
      #1;
      chk("R7 stored word", memVal(int'(formed)), ptr);
      chk("R8 idle", 12'({busy, done}), 12'd0);
      return;
    end
    chk("R4 read strobe", 12'({memRdEn, memWrEn, done, busy}), 12'b1000);
    chk({pgTag, " memAddr"}, memAddr, formed);

    @(negedge clk);
    reqValid = holdReq; instrWord = 12'h055; instrAddr = ~pc;
    #1;
    chk("R8 busy", 12'(busy), 12'd1);
    if (!autoInc) begin
      chk("R4 done", 12'({done, memWrEn, memRdEn}), 12'b100);
      chk("R4 effAddr", effAddr, expEa);
    end else begin
      chk("R5 gap", 12'({done, memWrEn, memRdEn}), 12'b000);
      @(negedge clk);
      #1;
      chk("R5 write", 12'({done, memWrEn, memRdEn, busy}), 12'b1101);
      chk("R5 write addr", memAddr, formed);
      chk("R6 write data", memWrData, expEa);
      chk("R5 effAddr", effAddr, expEa);
    end
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    chk("R8 refused while busy", 12'({busy, done}), 12'd0);
    chk("R5 memory after", memVal(int'(formed)), autoInc ? expEa : ptr);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset", 12'({busy, done, memRdEn, memWrEn}), 12'd0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R10 idle", 12'({busy, done, memRdEn, memWrEn}), 12'd0);

    runReq(mk(0, 0, 7'h5A), 12'hC83, "R1", 0);
    runReq(mk(0, 1, 7'h11), 12'hC83, "R2", 0);
    runReq(mk(0, 0, 9), 12'h400, "R7", 0);
    runReq(mk(1, 0, 7'h20), 12'h300, "R4", 0);
    runReq(mk(1, 1, 7'h33), 12'hA85, "R2", 1);
    memArr[7'h40] = 12'd9;
    runReq(mk(1, 0, 7'h40), 12'h700, "R4", 0);
    memArr[12] = 12'h123;
    runReq(mk(1, 0, 12), 12'hFFF, "R5", 1);
    runReq(mk(1, 0, 12), 12'h100, "R5", 0);
    memArr[8] = 12'hFFF;
    runReq(mk(1, 0, 8), 12'h200, "R6", 0);
    runReq(mk(1, 0, 15), 12'h200, "R5", 0);
    runReq(mk(1, 0, 16), 12'h200, "R4", 0);
    runReq(mk(1, 0, 7), 12'h200, "R4", 0);
    runReq(mk(1, 1, 10), 12'h040, "R9", 0);
    runReq(mk(1, 1, 10), 12'h0C0, "R2", 0);
    runReq(mk(0, 0, 8), 12'h200, "R7", 0);
    chk("R7 pointer kept", memVal(8), 12'h000);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule